// File: doc/BRIEF.md
# Registered-and-latched 12/24-bit bus exchanger

This block joins one narrow word port to a wide port made of a low half and a high half, each half as wide as the narrow port. Toward the wide side, two clocked registers sample the narrow input word on the rising clock edge, each under its own active-low load enable. Asserting the low enable on one edge and the high enable on the next packs two successive narrow words into one wide word.

Toward the narrow side, each wide half passes through its own transparent latch. The latch follows its input while its active-low enable is low and holds while that enable is high. A select input picks which latched half drives the narrow output. This path uses no clock. The narrow side and the wide side each have an active-low output enable. Each tri-state output is modelled as a data vector plus a separate drive flag, and a top level may resolve the pair to high impedance.

Top module: `bus_exchanger`

## Requirements
- R1: While `rst` is high at a rising clock edge, both wide-side registers are cleared to zero on that edge.
- R2: On a rising edge with `rst` low, `wideLoOut` takes `narrowIn` when `loadLoN` is 0 and keeps its value when `loadLoN` is 1.
- R3: On a rising edge with `rst` low, `wideHiOut` takes `narrowIn` when `loadHiN` is 0 and keeps its value when `loadHiN` is 1.
- R4: Word X is loaded with only `loadLoN` low, then word Y is loaded on the next edge with only `loadHiN` low. After those two edges, {`wideHiOut`,`wideLoOut`} equals {Y,X}.
- R5: While `latchLoN` is 0, the low latch follows `wideLoIn` with no clock. While `latchLoN` is 1, the low latch holds its last value whatever `wideLoIn` does.
- R6: While `latchHiN` is 0, the high latch follows `wideHiIn` with no clock. While `latchHiN` is 1, the high latch holds its last value whatever `wideHiIn` does.
- R7: `narrowOut` shows the low latch when `selLo` is 1 and the high latch when `selLo` is 0. A change of `selLo` takes effect with no clock edge.
- R8: `narrowDrv` is 1 exactly when `outEnNarrowN` is 0, and `wideDrv` is 1 exactly when `outEnWideN` is 0. All four combinations of the two enables work.
- R9: The wide-side registers load by R2 and R3 even while `outEnWideN` is 1. The enable changes only `wideDrv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the wide-side registers |
| rst | input | 1 | Synchronous active-high reset of the registers |
| narrowIn | input | 12 | Narrow word sampled by the registers |
| loadLoN | input | 1 | Active-low load enable, low register |
| loadHiN | input | 1 | Active-low load enable, high register |
| wideLoIn | input | 12 | Wide low-half input to the low latch |
| wideHiIn | input | 12 | Wide high-half input to the high latch |
| latchLoN | input | 1 | Active-low transparency enable, low latch |
| latchHiN | input | 1 | Active-low transparency enable, high latch |
| selLo | input | 1 | 1 selects the low latch for the narrow output, 0 the high latch |
| outEnNarrowN | input | 1 | Active-low narrow-side output enable |
| outEnWideN | input | 1 | Active-low wide-side output enable |
| narrowOut | output | 12 | Narrow output data |
| narrowDrv | output | 1 | Narrow output is driven |
| wideLoOut | output | 12 | Low register contents |
| wideHiOut | output | 12 | High register contents |
| wideDrv | output | 1 | Wide outputs are driven |

## Verification
The hardest state to reach is a closed latch whose held value differs from its live input while the select points at the other latch. In that state a fault in the hold, in the select or in a latch enable shows only after a later select change. The stimulus opens both latches with distinct words and closes them. It then moves the inputs to new words and switches the select, and opens one latch at a time while the select points at each side. The register path is swept over all combinations of the two load enables and the wide output enable, with changing data, against a bench model of the two registers.

// File: rtl/bxch_pkg.sv
package bxch_pkg;

  // strobes from control to datapath, index 0 = low half, 1 = high half
  typedef struct packed {
    logic [1:0] load;
    logic [1:0] pass;
    logic       pickLo;
    logic       driveNarrow;
    logic       driveWide;
  } bxch_strobe_t;

endpackage

// File: rtl/bxch_ctrl.sv
module bxch_ctrl
  import bxch_pkg::*;
(
  input  logic         loadLoN,
  input  logic         loadHiN,
  input  logic         latchLoN,
  input  logic         latchHiN,
  input  logic         selLo,
  input  logic         outEnNarrowN,
  input  logic         outEnWideN,
  output bxch_strobe_t strobe
);

  always_comb begin
    strobe.load        = {~loadHiN, ~loadLoN};
    strobe.pass        = {~latchHiN, ~latchLoN};
    strobe.pickLo      = selLo;
    strobe.driveNarrow = ~outEnNarrowN;
    strobe.driveWide   = ~outEnWideN;
  end

endmodule

// File: rtl/bxch_half.sv
module bxch_half #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              pass,
  input  logic [WORD_W-1:0] dIn,
  input  logic [WORD_W-1:0] wIn,
  output logic [WORD_W-1:0] regQ,
  output logic [WORD_W-1:0] latQ
);

  // narrow-to-wide register
  always_ff @(posedge clk) begin
    if (rst)       regQ <= '0;
    else if (load) regQ <= dIn;
  end

  // wide-to-narrow transparent latch, no reset
  always_latch begin
    if (pass) latQ = wIn;
  end

endmodule

// File: rtl/bxch_dpath.sv
module bxch_dpath
  import bxch_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int HALVES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bxch_strobe_t      strobe,
  input  logic [WORD_W-1:0] narrowIn,
  input  logic [WORD_W-1:0] wideLoIn,
  input  logic [WORD_W-1:0] wideHiIn,
  output logic [WORD_W-1:0] narrowOut,
  output logic              narrowDrv,
  output logic [WORD_W-1:0] wideLoOut,
  output logic [WORD_W-1:0] wideHiOut,
  output logic              wideDrv
);

  logic [HALVES-1:0][WORD_W-1:0] wideIn;
  logic [HALVES-1:0][WORD_W-1:0] regBank;
  logic [HALVES-1:0][WORD_W-1:0] latBank;

  assign wideIn = {wideHiIn, wideLoIn};

  for (genvar h = 0; h < HALVES; h++) begin : gHalf
    bxch_half #(.WORD_W(WORD_W)) uHalf (
      .clk  (clk),
      .rst  (rst),
      .load (strobe.load[h]),
      .pass (strobe.pass[h]),
      .dIn  (narrowIn),
      .wIn  (wideIn[h]),
      .regQ (regBank[h]),
      .latQ (latBank[h])
    );
  end

  assign narrowOut = strobe.pickLo ? latBank[0] : latBank[1];
  assign narrowDrv = strobe.driveNarrow;
  assign wideLoOut = regBank[0];
  assign wideHiOut = regBank[1];
  assign wideDrv   = strobe.driveWide;

endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bxch_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] narrowIn,
  input  logic              loadLoN,
  input  logic              loadHiN,
  input  logic [WORD_W-1:0] wideLoIn,
  input  logic [WORD_W-1:0] wideHiIn,
  input  logic              latchLoN,
  input  logic              latchHiN,
  input  logic              selLo,
  input  logic              outEnNarrowN,
  input  logic              outEnWideN,
  output logic [WORD_W-1:0] narrowOut,
  output logic              narrowDrv,
  output logic [WORD_W-1:0] wideLoOut,
  output logic [WORD_W-1:0] wideHiOut,
  output logic              wideDrv
);

  localparam int HALVES = 2;

  bxch_strobe_t strobe;

  bxch_ctrl uCtrl (
    .loadLoN      (loadLoN),
    .loadHiN      (loadHiN),
    .latchLoN     (latchLoN),
    .latchHiN     (latchHiN),
    .selLo        (selLo),
    .outEnNarrowN (outEnNarrowN),
    .outEnWideN   (outEnWideN),
    .strobe       (strobe)
  );

  bxch_dpath #(.WORD_W(WORD_W), .HALVES(HALVES)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .narrowIn  (narrowIn),
    .wideLoIn  (wideLoIn),
    .wideHiIn  (wideHiIn),
    .narrowOut (narrowOut),
    .narrowDrv (narrowDrv),
    .wideLoOut (wideLoOut),
    .wideHiOut (wideHiOut),
    .wideDrv   (wideDrv)
  );

endmodule

// File: rtl/bxch_checker.sv
module bxch_checker #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] narrowIn,
  input logic              loadLoN,
  input logic              loadHiN,
  input logic [WORD_W-1:0] wideLoIn,
  input logic [WORD_W-1:0] wideHiIn,
  input logic              latchLoN,
  input logic              latchHiN,
  input logic              selLo,
  input logic              outEnNarrowN,
  input logic              outEnWideN,
  input logic [WORD_W-1:0] narrowOut,
  input logic              narrowDrv,
  input logic [WORD_W-1:0] wideLoOut,
  input logic [WORD_W-1:0] wideHiOut,
  input logic              wideDrv
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (wideLoOut == '0) && (wideHiOut == '0));

  assert_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
    !loadLoN |=> wideLoOut == $past(narrowIn));

  assert_lo_hold_R2: assert property (@(posedge clk) disable iff (rst)
    loadLoN |=> $stable(wideLoOut));

  assert_hi_load_R3: assert property (@(posedge clk) disable iff (rst)
    !loadHiN |=> wideHiOut == $past(narrowIn));

  assert_hi_hold_R3: assert property (@(posedge clk) disable iff (rst)
    loadHiN |=> $stable(wideHiOut));

  assert_lo_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (!latchLoN && selLo) |-> narrowOut == wideLoIn);

  assert_hi_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (!latchHiN && !selLo) |-> narrowOut == wideHiIn);

  assert_drive_flags_R8: assert property (@(posedge clk)
    (narrowDrv != outEnNarrowN) && (wideDrv != outEnWideN));

endmodule

bind bus_exchanger bxch_checker #(.WORD_W(WORD_W)) uChk (.*);

// File: tb/bus_exchanger_tb.sv
module bus_exchanger_tb;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] narrowIn;
  logic         loadLoN, loadHiN;
  logic [W-1:0] wideLoIn, wideHiIn;
  logic         latchLoN, latchHiN, selLo;
  logic         outEnNarrowN, outEnWideN;
  logic [W-1:0] narrowOut, wideLoOut, wideHiOut;
  logic         narrowDrv, wideDrv;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_exchanger #(.WORD_W(W)) u_dut (
    .clk(clk), .rst(rst), .narrowIn(narrowIn),
    .loadLoN(loadLoN), .loadHiN(loadHiN),
    .wideLoIn(wideLoIn), .wideHiIn(wideHiIn),
    .latchLoN(latchLoN), .latchHiN(latchHiN), .selLo(selLo),
    .outEnNarrowN(outEnNarrowN), .outEnWideN(outEnWideN),
    .narrowOut(narrowOut), .narrowDrv(narrowDrv),
    .wideLoOut(wideLoOut), .wideHiOut(wideHiOut), .wideDrv(wideDrv)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // step to just after the next rising edge
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] mLo, mHi;
    rst = 1; narrowIn = 12'hFFF; loadLoN = 0; loadHiN = 0;
    wideLoIn = 0; wideHiIn = 0; latchLoN = 1; latchHiN = 1; selLo = 1;
    outEnNarrowN = 1; outEnWideN = 0;
    tick(); tick();
    // R1: reset clears both registers even with loads enabled
    check("R1 reset", {wideHiOut, wideLoOut}, 24'h0);
    rst = 0;
    mLo = 0; mHi = 0;

    // R8: all four enable combinations
    for (int e = 0; e < 4; e++) begin
      outEnNarrowN = e[0]; outEnWideN = e[1];
      #1;
      check("R8 drive flags", {22'h0, narrowDrv, wideDrv}, {22'h0, ~e[0], ~e[1]});
    end

    // R2 R3 R9: sweep load enables and wide output enable
    for (int i = 0; i < 32; i++) begin
      loadLoN = i[0]; loadHiN = i[1]; outEnWideN = i[2];
      narrowIn = W'(12'h5A3 ^ (i * 12'h111));
      tick();
      if (!i[0]) mLo = narrowIn;
      if (!i[1]) mHi = narrowIn;
      check(i[2] ? "R9 lo under disabled drive" : "R2 lo register", {12'h0, wideLoOut}, {12'h0, mLo});
      check(i[2] ? "R9 hi under disabled drive" : "R3 hi register", {12'h0, wideHiOut}, {12'h0, mHi});
      check("R8 wide flag", {23'h0, wideDrv}, {23'h0, ~i[2]});
    end

    // R4: packing two words
    outEnWideN = 0;
    narrowIn = 12'hABC; loadLoN = 0; loadHiN = 1; tick();
    narrowIn = 12'h123; loadLoN = 1; loadHiN = 0; tick();
    loadHiN = 1; narrowIn = 12'h777; tick();
    check("R4 packed word", {wideHiOut, wideLoOut}, 24'h123ABC);

    // latches: open both with distinct words
    outEnNarrowN = 0;
    wideLoIn = 12'h111; wideHiIn = 12'h222; latchLoN = 0; latchHiN = 0;
    selLo = 1; #1;
    check("R5 lo transparent", {12'h0, narrowOut}, 24'h111);
    selLo = 0; #1;
    check("R7 select hi", {12'h0, narrowOut}, 24'h222);
    latchLoN = 1; latchHiN = 1; #1;
    wideLoIn = 12'hEEE; wideHiIn = 12'hDDD; #1;
    check("R6 hi holds", {12'h0, narrowOut}, 24'h222);
    selLo = 1; #1;
    check("R7 select lo held", {12'h0, narrowOut}, 24'h111);
    latchHiN = 0; #1;
    check("R5 lo holds while hi opens", {12'h0, narrowOut}, 24'h111);
    selLo = 0; #1;
    check("R6 hi transparent", {12'h0, narrowOut}, 24'hDDD);
    latchHiN = 1; #1;
    selLo = 1; latchLoN = 0; #1;
    check("R5 lo reopened", {12'h0, narrowOut}, 24'hEEE);
    latchLoN = 1; #1;

    // sweep of latch hold/pass with select
    for (int k = 0; k < 16; k++) begin
      logic [W-1:0] hLo, hHi;
      hLo = W'(k * 12'h0F3 + 12'h00A);
      hHi = W'(~(k * 12'h31));
      wideLoIn = hLo; wideHiIn = hHi;
      latchLoN = 0; latchHiN = 0; #1;
      latchLoN = 1; latchHiN = 1; #1;
      wideLoIn = ~hLo; wideHiIn = ~hHi;
      selLo = k[0]; #1;
      check(k[0] ? "R5 held lo sweep" : "R6 held hi sweep",
            {12'h0, narrowOut}, {12'h0, k[0] ? hLo : hHi});
      selLo = ~k[0]; #1;
      check("R7 select sweep", {12'h0, narrowOut}, {12'h0, k[0] ? hHi : hLo});
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule